// File: doc/BRIEF.md
# Three-wire control word receiver

This block is a synchronous slave that takes configuration words from a three-pin serial bus made of a bus clock, a data line and an active-low enable. The three pins are sampled by a much faster system clock, at least four times the bus clock rate. Each pin passes through a synchronizer chain, and the edges of the bus clock and the enable are found in the system clock domain.

While the enable is low, each rising edge of the bus clock appends one data bit to a fixed-length frame register, most significant bit first. When the enable returns high, the last bit shifted in acts as an address and chooses one of two holding registers:

- A 1 chooses the 23-bit channel word, which holds the synthesizer and modulation settings.
- A 0 chooses the 13-bit setup word, which holds the output power, the DAC and the test-output settings.

The chosen register is decoded into registered field outputs, and a one-cycle update strobe marks which register changed. Leading bits beyond the frame length fall off the register and are ignored. No count of clock pulses is kept.

Top module: `wire3_cfg_rx`

## Requirements
- R1: After reset every holding register reads as all zeros, so the outputs are: refDiv8=0, swallowCnt=0, mainCnt=80, vcoSel=0, devScale=0, cpStep=-1, gaussEn=0, paLevel=0, dacCode=0, testSel=0, and both strobes are low.
- R2: While busEnN is low, each rising edge of busClk appends the current busData value to the frame, and the first bit sent is the most significant.
- R3: The holding registers change only on a low-to-high transition of busEnN. The outputs and the strobe take their new values on the third rising edge of the system clock after busEnN rises, counting two synchronizer stages and one register stage.
- R4: If the last bit received is 1, the 23 bits before it load the channel word, with D22 sent first. chanUpd is then high for exactly one cycle.
- R5: If the last bit received is 0, the 13 bits before it load the setup word, with E12 sent first. setupUpd is then high for exactly one cycle.
- R6: The frame holds the last 24 bits received. Surplus leading bits are dropped without effect. A short transfer leaves earlier bits in the leading positions, because the number of pulses is never checked.
- R7: The channel fields map as follows: refDiv8 = D22 (0 selects divide by 6, 1 selects divide by 8); swallowCnt = D21..D17; vcoSel = D12; devScale = D9..D7; gaussEn = D0.
- R8: mainCnt equals 80 plus the 4-bit field D16..D13, so its range is 80 to 95.
- R9: The charge-pump step cpStep is signed. It maps the code D2..D1 as 00 to -1, 01 to 0, 10 to +1 and 11 to +2.
- R10: The setup fields map as paLevel = E12..E11, dacCode = E10..E6 and testSel = E2..E0. Bits E5..E3 have no effect on any output.
- R11: A load changes only the addressed register. The other register keeps its contents, and the two strobes are never high together.
- R12: A busClk rise that first appears in the same system-clock sample as the busEnN rise is not shifted in. The load uses the frame as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busClk | input | 1 | Serial bus clock |
| busData | input | 1 | Serial bus data |
| busEnN | input | 1 | Serial bus enable, low while a frame is sent |
| refDiv8 | output | 1 | Reference divide select (1 selects /8) |
| swallowCnt | output | 5 | Swallow counter value |
| mainCnt | output | 7 | Main counter value, 80 to 95 |
| vcoSel | output | 1 | VCO select |
| devScale | output | 3 | Deviation scaling code |
| cpStep | output | 3 | Signed charge-pump step, -1 to +2 |
| gaussEn | output | 1 | Gaussian filter enable |
| chanUpd | output | 1 | One-cycle strobe: the channel word was loaded |
| paLevel | output | 2 | Output power level |
| dacCode | output | 5 | DAC value |
| testSel | output | 3 | Test-output select |
| setupUpd | output | 1 | One-cycle strobe: the setup word was loaded |

## Verification
Two things can fall into the same synchronized sample: the final rise of busClk and the rise of busEnN that ends the frame. The bench provokes this by driving both pins high at the same instant. The bit on busData at that moment is chosen so that, if it were shifted, it would move the address from the channel word to the setup word. A reference model that queues bits only while the enable is low is compared with every output on every clock. The check therefore passes only when the channel word loads from the frame as it stood before that edge and setupUpd stays low.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

  // Data bits in each word, not counting the address bit.
  localparam int CHAN_BITS  = 23;
  localparam int SETUP_BITS = 13;
  localparam int FRAME_W    = CHAN_BITS + 1;

  // Commands from the control module to the datapath, one set per system cycle.
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadEn;
  } busCmd_t;

  typedef struct packed {
    logic       refSel;
    logic [4:0] swallow;
    logic [3:0] mainCode;
    logic       vcoSel;
    logic [2:0] devCode;
    logic [1:0] cpCode;
    logic       gaussEn;
  } chanWord_t;

  typedef struct packed {
    logic [1:0] paLevel;
    logic [4:0] dac;
    logic [2:0] testSel;
  } setupWord_t;

endpackage

// File: rtl/cfgrx_ctrl.sv
module cfgrx_ctrl
  import cfgrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    busClk,
  input  logic    busData,
  input  logic    busEnN,
  output busCmd_t cmd
);

  localparam int NUM_PINS = 3;
  localparam int LAST     = SYNC_STAGES - 1;
  // Pin order in the packed vectors: 0 = clock, 1 = data, 2 = enable.
  localparam logic [NUM_PINS-1:0] IDLE_LEVEL = 3'b100;

  logic [NUM_PINS-1:0] pinIn;
  logic [NUM_PINS-1:0] pinSync;
  logic                clkLast;
  logic                enLast;
  logic                clkRise;
  logic                enRise;

  assign pinIn = {busEnN, busData, busClk};

  for (genvar p = 0; p < NUM_PINS; p++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= {SYNC_STAGES{IDLE_LEVEL[p]}};
      else       chain <= {chain[SYNC_STAGES-2:0], pinIn[p]};
    end
    assign pinSync[p] = chain[LAST];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkLast <= 1'b0;
      enLast  <= 1'b1;
    end else begin
      clkLast <= pinSync[0];
      enLast  <= pinSync[2];
    end
  end

  assign clkRise      = pinSync[0] && !clkLast;
  assign enRise       = pinSync[2] && !enLast;
  assign cmd.shiftEn  = clkRise && !pinSync[2];
  assign cmd.shiftBit = pinSync[1];
  assign cmd.loadEn   = enRise;

  // R3
  load_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadEn |=> !cmd.loadEn);

  // R12
  shift_load_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.shiftEn && cmd.loadEn));

endmodule

// File: rtl/cfgrx_datapath.sv
module cfgrx_datapath
  import cfgrx_pkg::*;
#(
  parameter int MAIN_BASE = 80
) (
  input  logic             clk,
  input  logic             rstN,
  input  busCmd_t          cmd,
  output logic             refDiv8,
  output logic [4:0]       swallowCnt,
  output logic [6:0]       mainCnt,
  output logic             vcoSel,
  output logic [2:0]       devScale,
  output logic signed [2:0] cpStep,
  output logic             gaussEn,
  output logic             chanUpd,
  output logic [1:0]       paLevel,
  output logic [4:0]       dacCode,
  output logic [2:0]       testSel,
  output logic             setupUpd
);

  localparam logic [6:0] MAIN_OFS = 7'(MAIN_BASE);

  logic [FRAME_W-1:0]    frame;
  logic [CHAN_BITS-1:0]  chanBits;
  logic [SETUP_BITS-1:0] setupBits;
  chanWord_t             chanReg;
  setupWord_t            setupReg;

  assign chanBits  = frame[FRAME_W-1:1];
  assign setupBits = frame[SETUP_BITS:1];

  always_ff @(posedge clk) begin
    if (!rstN) frame <= '0;
    else if (cmd.shiftEn) frame <= {frame[FRAME_W-2:0], cmd.shiftBit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanReg  <= '0;
      setupReg <= '0;
      chanUpd  <= 1'b0;
      setupUpd <= 1'b0;
    end else begin
      chanUpd  <= 1'b0;
      setupUpd <= 1'b0;
      if (cmd.loadEn) begin
        if (frame[0]) begin
          chanReg.refSel   <= chanBits[22];
          chanReg.swallow  <= chanBits[21:17];
          chanReg.mainCode <= chanBits[16:13];
          chanReg.vcoSel   <= chanBits[12];
          chanReg.devCode  <= chanBits[9:7];
          chanReg.cpCode   <= chanBits[2:1];
          chanReg.gaussEn  <= chanBits[0];
          chanUpd          <= 1'b1;
        end else begin
          setupReg.paLevel <= setupBits[12:11];
          setupReg.dac     <= setupBits[10:6];
          setupReg.testSel <= setupBits[2:0];
          setupUpd         <= 1'b1;
        end
      end
    end
  end

  assign refDiv8    = chanReg.refSel;
  assign swallowCnt = chanReg.swallow;
  assign mainCnt    = MAIN_OFS + {3'b000, chanReg.mainCode};
  assign vcoSel     = chanReg.vcoSel;
  assign devScale   = chanReg.devCode;
  assign cpStep     = $signed({1'b0, chanReg.cpCode}) - 3'sd1;
  assign gaussEn    = chanReg.gaussEn;
  assign paLevel    = setupReg.paLevel;
  assign dacCode    = setupReg.dac;
  assign testSel    = setupReg.testSel;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(chanUpd && setupUpd));

  // R4
  chan_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanUpd |=> !chanUpd);

  // R5
  setup_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    setupUpd |=> !setupUpd);

  // R11
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanUpd |-> $stable(chanReg));

  // R11
  setup_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !setupUpd |-> $stable(setupReg));

  // R8
  main_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mainCnt >= MAIN_OFS) && (mainCnt <= MAIN_OFS + 7'd15));

  // R9
  cp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpStep >= -3'sd1) && (cpStep <= 3'sd2));

endmodule

// File: rtl/wire3_cfg_rx.sv
module wire3_cfg_rx
  import cfgrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAIN_BASE   = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busClk,
  input  logic              busData,
  input  logic              busEnN,
  output logic              refDiv8,
  output logic [4:0]        swallowCnt,
  output logic [6:0]        mainCnt,
  output logic              vcoSel,
  output logic [2:0]        devScale,
  output logic signed [2:0] cpStep,
  output logic              gaussEn,
  output logic              chanUpd,
  output logic [1:0]        paLevel,
  output logic [4:0]        dacCode,
  output logic [2:0]        testSel,
  output logic              setupUpd
);

  busCmd_t cmd;

  cfgrx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busClk  (busClk),
    .busData (busData),
    .busEnN  (busEnN),
    .cmd     (cmd)
  );

  cfgrx_datapath #(.MAIN_BASE(MAIN_BASE)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .refDiv8    (refDiv8),
    .swallowCnt (swallowCnt),
    .mainCnt    (mainCnt),
    .vcoSel     (vcoSel),
    .devScale   (devScale),
    .cpStep     (cpStep),
    .gaussEn    (gaussEn),
    .chanUpd    (chanUpd),
    .paLevel    (paLevel),
    .dacCode    (dacCode),
    .testSel    (testSel),
    .setupUpd   (setupUpd)
  );

endmodule

// File: tb/sim_wire3_cfg_rx.sv
module sim_wire3_cfg_rx;

  localparam int HALF  = 16;   // system cycles per bus clock half period
  localparam int GAP   = 70;   // system cycles between transfers
  localparam int FRAME = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busClk = 1'b0;
  logic busData = 1'b0;
  logic busEnN = 1'b1;

  logic              refDiv8, vcoSel, gaussEn, chanUpd, setupUpd;
  logic [4:0]        swallowCnt, dacCode;
  logic [6:0]        mainCnt;
  logic [2:0]        devScale, testSel;
  logic signed [2:0] cpStep;
  logic [1:0]        paLevel;

  wire3_cfg_rx u0 (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busData(busData), .busEnN(busEnN),
    .refDiv8(refDiv8), .swallowCnt(swallowCnt), .mainCnt(mainCnt), .vcoSel(vcoSel),
    .devScale(devScale), .cpStep(cpStep), .gaussEn(gaussEn), .chanUpd(chanUpd),
    .paLevel(paLevel), .dacCode(dacCode), .testSel(testSel), .setupUpd(setupUpd)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit comparing = 0;
  string scen = "R1";

  // Reference model state
  bit bitQ[$];
  int loadCd = 0;
  int eRef = 0, eSw = 0, eMain = 80, eVco = 0, eDev = 0, eCp = -1, eGf = 0, eChU = 0;
  int ePa = 0, eDac = 0, eTest = 0, eSetU = 0;

  task automatic check(input string req, input string name, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s (%s) %s actual=%0d expected=%0d at %0t", req, scen, name, act, exp, $time);
    end
  endtask

  // Behavioural model: loads from the last 24 queued bits when its countdown expires.
  always @(posedge clk) begin
    eChU = 0;
    eSetU = 0;
    if (loadCd > 0) begin
      loadCd--;
      if (loadCd == 0) begin
        int w;
        int n;
        w = 0;
        n = bitQ.size();
        for (int i = n - FRAME; i < n - 1; i++) w = (w << 1) | int'(bitQ[i]);
        if (bitQ[n-1]) begin
          eRef  = (w >> 22) & 1;
          eSw   = (w >> 17) & 31;
          eMain = 80 + ((w >> 13) & 15);
          eVco  = (w >> 12) & 1;
          eDev  = (w >> 7) & 7;
          eCp   = ((w >> 1) & 3) - 1;
          eGf   = w & 1;
          eChU  = 1;
        end else begin
          ePa   = (w >> 11) & 3;
          eDac  = (w >> 6) & 31;
          eTest = w & 7;
          eSetU = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (comparing) begin
      check("R7",  "refDiv8",    int'(refDiv8),     eRef);
      check("R7",  "swallowCnt", int'(swallowCnt),  eSw);
      check("R8",  "mainCnt",    int'(mainCnt),     eMain);
      check("R7",  "vcoSel",     int'(vcoSel),      eVco);
      check("R7",  "devScale",   int'(devScale),    eDev);
      check("R9",  "cpStep",     int'(cpStep),      eCp);
      check("R7",  "gaussEn",    int'(gaussEn),     eGf);
      check("R4",  "chanUpd",    int'(chanUpd),     eChU);
      check("R10", "paLevel",    int'(paLevel),     ePa);
      check("R10", "dacCode",    int'(dacCode),     eDac);
      check("R10", "testSel",    int'(testSel),     eTest);
      check("R5",  "setupUpd",   int'(setupUpd),    eSetU);
    end
  end

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busBit(input bit b);
    busData = b;
    waitEdges(HALF);
    busClk = 1'b1;
    if (!busEnN) begin
      bitQ.push_back(b);
      if (bitQ.size() > FRAME) void'(bitQ.pop_front());
    end
    waitEdges(HALF);
    busClk = 1'b0;
  endtask

  task automatic openFrame(input logic [63:0] bits, input int n);
    waitEdges(4);
    busEnN = 1'b0;
    for (int i = n - 1; i >= 0; i--) busBit(bits[i]);
  endtask

  task automatic closeFrame();
    waitEdges(HALF);
    busEnN = 1'b1;
    loadCd = 3;
    waitEdges(GAP);
  endtask

  task automatic sendWord(input string s, input logic [63:0] bits, input int n);
    scen = s;
    openFrame(bits, n);
    closeFrame();
  endtask

  initial begin
    for (int i = 0; i < FRAME; i++) bitQ.push_back(1'b0);
    waitEdges(5);
    rstN = 1'b1;
    waitEdges(1);
    // R1: reset values at the ports
    scen = "R1";
    check("R1", "reset mainCnt", int'(mainCnt), 80);
    check("R1", "reset cpStep", int'(cpStep), -1);
    check("R1", "reset swallowCnt", int'(swallowCnt), 0);
    check("R1", "reset strobes", int'({chanUpd, setupUpd}), 0);
    comparing = 1;

    // R2 R4 R7 R8 R9: channel words, code 00
    sendWord("R2", 64'({23'h5A3C71, 1'b1}), 24);
    // R5 R11: setup word leaves the channel fields untouched
    sendWord("R5", 64'({13'h1A5F, 1'b0}), 14);
    // R9: codes 01 and 10
    sendWord("R9", 64'({23'h3C9A82, 1'b1}), 24);
    sendWord("R9", 64'({23'h61E6C5, 1'b1}), 24);
    // R6: surplus leading bits
    sendWord("R6", 64'({8'hFF, 23'h2B1D4E, 1'b1}), 32);
    // R10: only E5..E3 differ
    sendWord("R10", 64'({13'h0A47, 1'b0}), 14);
    sendWord("R10", 64'({13'h0A7F, 1'b0}), 14);
    // R8 R9 R7: extremes
    sendWord("R8", 64'({23'h7FFFFF, 1'b1}), 24);
    sendWord("R8", 64'({23'h000000, 1'b1}), 24);
    // R6: short frame keeps stale leading bits
    sendWord("R6", 64'({9'h1B3, 1'b1}), 10);
    sendWord("R5", 64'({13'h1FFF, 1'b0}), 14);
    // R3: enable pulse with no clocks reloads the same frame
    sendWord("R3", 64'd0, 0);

    // R12: clock rise and enable rise presented together
    scen = "R12";
    openFrame(64'({23'h4D2B17, 1'b1}), 24);
    busData = 1'b0;
    waitEdges(HALF);
    busClk = 1'b1;
    busEnN = 1'b1;
    loadCd = 3;
    waitEdges(HALF);
    busClk = 1'b0;
    waitEdges(GAP);

    comparing = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule